// File: doc/BRIEF.md
# Two-Channel Interrupt Vector Arbiter

This block holds the interrupt bookkeeping that two serial channels share. Each channel has a receive source and a transmit source. Each source is raised by a set pulse and dropped by a clear pulse. A per-channel service state machine records which of the two sources owns the channel's "in service" token. Only the owner of the token may write the shared vector register. A second source that arrives while the token is held marks itself pending and waits. When the owner is cleared, it hands the token to the waiting source.

The vector register is one byte that both channels write. It encodes the channel and the kind of interrupt. A mode input selects whether the code sits in the low bits or the high bits of the byte. A pending byte shows every source at a fixed bit position. Each channel raises its own request line from a five-bit interrupt control field and a break enable. The two request lines are ORed into one registered interrupt output.

Index 1 of every two-bit port is channel A. Index 0 is channel B.

Top module: `vec_arbiter`

## Requirements
- R1: After reset, `vector` is 0x06, `pending` is 0x00 and `irq` is 0.
- R2: Pending bit positions in `pending` are: bit 5 = A rx, bit 4 = A tx, bit 3 = A break, bit 2 = B rx, bit 1 = B tx, bit 0 = B break. Bits 7:6 are zero. A break bit is `brk_en & brk_stat` of its channel.
- R3: With `status_hi` = 0, a vector write stores these codes: A rx 0x0C, A tx 0x08, B rx 0x04, B tx 0x00, no interrupt 0x06.
- R4: With `status_hi` = 1, a vector write stores these codes: A rx 0x30, A tx 0x10, B rx 0x20, B tx 0x00, no interrupt 0x60. The mode is sampled only when a write happens, so changing `status_hi` alone leaves `vector` unchanged.
- R5: A set pulse always sets its pending bit on the next edge. An rx set moves the channel to RX_SVC and writes the rx code, unless the channel is in TX_SVC. A tx set behaves the same way, unless the channel is in RX_SVC.
- R6: When rx and tx set pulses of one channel come in the same cycle, rx is handled first. Both pending bits are set, the rx code is written and the channel ends in RX_SVC.
- R7: A clear of a source drops its pending bit. If the other source of that channel is still pending, the channel moves to that source's service state and writes that source's code. Otherwise it goes to IDLE and writes the no-interrupt code. In the same cycle, `rx_clr` takes precedence over `tx_clr`, and that `tx_clr` is ignored.
- R8: `ius_clr` clears the rx source when the channel is in RX_SVC, and the tx source when it is in TX_SVC, with the effects of R7. In IDLE it does nothing. While `ius_clr` is high, the explicit clear pulses of that channel are ignored. Clears are applied before sets of the same cycle.
- R9: When both channels write the vector in the same cycle, channel A's code is stored.
- R10: `chan_irq` of a channel is 1 when control bit 0 is set and at least one of these holds: control bit 1 and tx pending; control bits [4:3] equal 01 or 10 and rx pending; `brk_en` and `brk_stat`.
- R11: `irq` equals the OR of `chan_irq` one cycle earlier.
- R12: `vector` keeps its value in any cycle in which no channel writes it.

Each channel's service state machine has three states: IDLE, RX_SVC and TX_SVC. Its transitions are:
- IDLE→RX_SVC on an rx set.
- IDLE→TX_SVC on a tx set without an rx set.
- RX_SVC→TX_SVC on an rx clear while tx is pending.
- TX_SVC→RX_SVC on a tx clear while rx is pending.
- RX_SVC→IDLE and TX_SVC→IDLE on a clear with nothing else pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_hi | input | 1 | Vector placement mode, 1 = high bits |
| rx_set | input | 2 | Receive interrupt set pulse per channel |
| tx_set | input | 2 | Transmit interrupt set pulse per channel |
| rx_clr | input | 2 | Receive interrupt clear pulse per channel |
| tx_clr | input | 2 | Transmit interrupt clear pulse per channel |
| ius_clr | input | 2 | Clear-in-service pulse per channel |
| int_ctrl_a | input | 5 | Channel A control: bit0 master, bit1 tx, [4:3] rx mode |
| int_ctrl_b | input | 5 | Channel B control, same layout |
| brk_en | input | 2 | Break interrupt enable per channel |
| brk_stat | input | 2 | Break status per channel |
| vector | output | 8 | Shared interrupt vector |
| pending | output | 8 | Pending bits as in R2 |
| chan_irq | output | 2 | Per-channel request |
| irq | output | 1 | Registered OR of the channel requests |

## Verification
The assertions assume that every input is synchronous to `clk` and holds steady across each sampling edge. They also assume that the clear-priority rules of R7 and R8 hold, so the pending-clear property is guarded against a same-cycle `ius_clr` or set. The stimulus changes inputs only at falling edges. It draws random pulses with low probability, so both the blocking paths and the collisions between set and clear pulses in one cycle come up often. Directed sequences force the exact orderings: both sets at once, both channels writing at once, and `ius_clr` in IDLE.

// File: rtl/vec_arb_pkg.sv
package vec_arb_pkg;
    localparam int NCH    = 2;
    localparam int VEC_W  = 8;
    localparam int CTRL_W = 5;
    localparam int CH_B   = 0;
    localparam int CH_A   = 1;

    typedef enum logic [1:0] {SVC_IDLE = 2'd0, SVC_RX = 2'd1, SVC_TX = 2'd2} svc_state_e;
    typedef enum logic [1:0] {VK_NONE = 2'd0, VK_RX = 2'd1, VK_TX = 2'd2} vec_kind_e;

    function automatic logic [VEC_W-1:0] enc_vector(input logic hi, input logic is_a,
                                                    input vec_kind_e k);
        logic [VEC_W-1:0] v;
        unique case (k)
            VK_RX:   v = is_a ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
            VK_TX:   v = is_a ? (hi ? 8'h10 : 8'h08) : 8'h00;
            default: v = hi ? 8'h60 : 8'h06;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/vec_arb_chan.sv
module vec_arb_chan
    import vec_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_set,
    input  logic      tx_set,
    input  logic      rx_clr,
    input  logic      tx_clr,
    input  logic      ius_clr,
    output logic      pend_rx,
    output logic      pend_tx,
    output logic      vec_wr,
    output vec_kind_e vec_kind
);
    svc_state_e state_q, state_d;
    logic       prx_q, prx_d, ptx_q, ptx_d;
    logic       do_crx, do_ctx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SVC_IDLE;
            prx_q   <= 1'b0;
            ptx_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            prx_q   <= prx_d;
            ptx_q   <= ptx_d;
        end
    end

    // clear selection: in-service clear beats explicit clears, rx beats tx
    always_comb begin
        do_crx = 1'b0;
        do_ctx = 1'b0;
        if (ius_clr) begin
            unique case (state_q)
                SVC_RX:   do_crx = 1'b1;
                SVC_TX:   do_ctx = 1'b1;
                default:  ;
            endcase
        end else if (rx_clr) begin
            do_crx = 1'b1;
        end else if (tx_clr) begin
            do_ctx = 1'b1;
        end
    end

    // next state and vector request
    always_comb begin
        state_d  = state_q;
        prx_d    = prx_q;
        ptx_d    = ptx_q;
        vec_wr   = 1'b0;
        vec_kind = VK_NONE;
        if (do_crx) begin
            prx_d  = 1'b0;
            vec_wr = 1'b1;
            if (ptx_q) begin
                state_d  = SVC_TX;
                vec_kind = VK_TX;
            end else begin
                state_d  = SVC_IDLE;
            end
        end else if (do_ctx) begin
            ptx_d  = 1'b0;
            vec_wr = 1'b1;
            if (prx_q) begin
                state_d  = SVC_RX;
                vec_kind = VK_RX;
            end else begin
                state_d  = SVC_IDLE;
            end
        end
        if (rx_set) begin
            prx_d = 1'b1;
            if (state_d != SVC_TX) begin
                state_d  = SVC_RX;
                vec_wr   = 1'b1;
                vec_kind = VK_RX;
            end
        end
        if (tx_set) begin
            ptx_d = 1'b1;
            if (state_d != SVC_RX) begin
                state_d  = SVC_TX;
                vec_wr   = 1'b1;
                vec_kind = VK_TX;
            end
        end
    end

    // outputs
    always_comb begin
        pend_rx = prx_q;
        pend_tx = ptx_q;
    end
endmodule

// File: rtl/vec_arb_irq.sv
module vec_arb_irq
    import vec_arb_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              pend_rx,
    input  logic              pend_tx,
    input  logic              brk_en,
    input  logic              brk_stat,
    output logic              req
);
    logic rx_mode_on;
    always_comb begin
        rx_mode_on = (ctrl[4:3] == 2'b01) || (ctrl[4:3] == 2'b10);
        req = ctrl[0] && ((ctrl[1] && pend_tx) || (rx_mode_on && pend_rx) ||
                          (brk_en && brk_stat));
    end
endmodule

// File: rtl/vec_arbiter.sv
module vec_arbiter
    import vec_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              status_hi,
    input  logic [NCH-1:0]    rx_set,
    input  logic [NCH-1:0]    tx_set,
    input  logic [NCH-1:0]    rx_clr,
    input  logic [NCH-1:0]    tx_clr,
    input  logic [NCH-1:0]    ius_clr,
    input  logic [CTRL_W-1:0] int_ctrl_a,
    input  logic [CTRL_W-1:0] int_ctrl_b,
    input  logic [NCH-1:0]    brk_en,
    input  logic [NCH-1:0]    brk_stat,
    output logic [VEC_W-1:0]  vector,
    output logic [VEC_W-1:0]  pending,
    output logic [NCH-1:0]    chan_irq,
    output logic              irq
);
    logic [NCH-1:0] p_rx, p_tx, v_wr;
    vec_kind_e      v_kind [NCH];
    logic [CTRL_W-1:0] ctrl [NCH];
    logic [VEC_W-1:0]  vec_q;
    logic              irq_q;

    always_comb begin
        ctrl[CH_A] = int_ctrl_a;
        ctrl[CH_B] = int_ctrl_b;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        vec_arb_chan u_chan (
            .clk(clk), .rst_n(rst_n),
            .rx_set(rx_set[c]), .tx_set(tx_set[c]),
            .rx_clr(rx_clr[c]), .tx_clr(tx_clr[c]), .ius_clr(ius_clr[c]),
            .pend_rx(p_rx[c]), .pend_tx(p_tx[c]),
            .vec_wr(v_wr[c]), .vec_kind(v_kind[c])
        );
        vec_arb_irq u_irq (
            .ctrl(ctrl[c]), .pend_rx(p_rx[c]), .pend_tx(p_tx[c]),
            .brk_en(brk_en[c]), .brk_stat(brk_stat[c]), .req(chan_irq[c])
        );
    end

    // shared vector register, channel A wins a same-cycle collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= 8'h06;
        end else if (v_wr[CH_A]) begin
            vec_q <= enc_vector(status_hi, 1'b1, v_kind[CH_A]);
        end else if (v_wr[CH_B]) begin
            vec_q <= enc_vector(status_hi, 1'b0, v_kind[CH_B]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |chan_irq;
    end

    always_comb begin
        vector  = vec_q;
        irq     = irq_q;
        pending = {2'b00, p_rx[CH_A], p_tx[CH_A], brk_en[CH_A] & brk_stat[CH_A],
                   p_rx[CH_B], p_tx[CH_B], brk_en[CH_B] & brk_stat[CH_B]};
    end
endmodule

// File: rtl/vec_arbiter_chk.sv
module vec_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rx_set,
    input logic [1:0] tx_set,
    input logic [1:0] rx_clr,
    input logic [1:0] tx_clr,
    input logic [1:0] ius_clr,
    input logic [4:0] int_ctrl_a,
    input logic [7:0] vector,
    input logic [7:0] pending,
    input logic [1:0] chan_irq,
    input logic       irq
);
    // R5: a set always leaves its pending bit up
    p_set_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set[1] |=> pending[5]);
    p_set_pend_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set[0] |=> pending[1]);
    // R7: an explicit rx clear with no competing pulse drops the bit
    p_clr_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr[1] && !ius_clr[1] && !rx_set[1]) |=> !pending[5]);
    // R12: quiet cycle keeps the vector
    p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_set | tx_set | rx_clr | tx_clr | ius_clr) == 2'b00) |=> $stable(vector));
    // R10: master enable gates channel A's request
    p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ctrl_a[0] |-> !chan_irq[1]);
    // R11: output is the registered OR
    p_irq_reg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == $past(|chan_irq)));
endmodule

bind vec_arbiter vec_arbiter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_set(rx_set), .tx_set(tx_set),
    .rx_clr(rx_clr), .tx_clr(tx_clr), .ius_clr(ius_clr), .int_ctrl_a(int_ctrl_a),
    .vector(vector), .pending(pending), .chan_irq(chan_irq), .irq(irq)
);

// File: tb/vec_arbiter_test.sv
`timescale 1ns/1ps
module vec_arbiter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic status_hi = 1'b0;
    logic [1:0] rx_set = 0, tx_set = 0, rx_clr = 0, tx_clr = 0, ius_clr = 0;
    logic [4:0] int_ctrl_a = 0, int_ctrl_b = 0;
    logic [1:0] brk_en = 0, brk_stat = 0;
    logic [7:0] vector, pending;
    logic [1:0] chan_irq;
    logic irq;

    int compared = 0, mismatched = 0;
    bit finished = 0;

    // model: svc 0 idle, 1 rx, 2 tx; index 1 = A
    int m_svc [2];
    bit m_prx [2], m_ptx [2];
    logic [7:0] m_vec;
    bit m_irq;

    always #10 clk = ~clk;

    vec_arbiter uut (.*);

    function automatic logic [7:0] exp_code(bit hi, bit is_a, int kind);
        if (kind == 1) return is_a ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
        if (kind == 2) return is_a ? (hi ? 8'h10 : 8'h08) : 8'h00;
        return hi ? 8'h60 : 8'h06;
    endfunction

    function automatic bit exp_req(logic [4:0] c, bit prx, bit ptx, bit be, bit bs);
        return c[0] && ((c[1] && ptx) || ((c[4:3] == 2'b01 || c[4:3] == 2'b10) && prx)
                        || (be && bs));
    endfunction

    function automatic logic [7:0] exp_pend();
        return {2'b00, m_prx[1], m_ptx[1], brk_en[1] & brk_stat[1],
                m_prx[0], m_ptx[0], brk_en[0] & brk_stat[0]};
    endfunction

    function automatic logic [1:0] exp_chirq();
        return {exp_req(int_ctrl_a, m_prx[1], m_ptx[1], brk_en[1], brk_stat[1]),
                exp_req(int_ctrl_b, m_prx[0], m_ptx[0], brk_en[0], brk_stat[0])};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // one channel's step; returns write flag and kind
    task automatic model_ch(int c, output bit wr, output int kind);
        bit crx = 0, ctx = 0;
        wr = 0; kind = 0;
        if (ius_clr[c]) begin
            crx = (m_svc[c] == 1); ctx = (m_svc[c] == 2);
        end else if (rx_clr[c]) crx = 1;
        else if (tx_clr[c]) ctx = 1;
        if (crx) begin
            m_prx[c] = 0; wr = 1;
            if (m_ptx[c]) begin m_svc[c] = 2; kind = 2; end else m_svc[c] = 0;
        end else if (ctx) begin
            m_ptx[c] = 0; wr = 1;
            if (m_prx[c]) begin m_svc[c] = 1; kind = 1; end else m_svc[c] = 0;
        end
        if (rx_set[c]) begin
            m_prx[c] = 1;
            if (m_svc[c] != 2) begin m_svc[c] = 1; wr = 1; kind = 1; end
        end
        if (tx_set[c]) begin
            m_ptx[c] = 1;
            if (m_svc[c] != 1) begin m_svc[c] = 2; wr = 1; kind = 2; end
        end
    endtask

    // inputs already set by caller (changed after a falling edge)
    task automatic tick();
        bit wa, wb;
        int ka, kb;
        m_irq = |exp_chirq();
        model_ch(1, wa, ka);
        model_ch(0, wb, kb);
        if (wa) m_vec = exp_code(status_hi, 1, ka);
        else if (wb) m_vec = exp_code(status_hi, 0, kb);
        @(posedge clk);
        #2;
        chk("R5 vector", vector, m_vec);
        chk("R2 pending", pending, exp_pend());
        chk("R10 chan_irq", {6'd0, chan_irq}, {6'd0, exp_chirq()});
        chk("R11 irq", {7'd0, irq}, {7'd0, m_irq});
        @(negedge clk);
        rx_set = 0; tx_set = 0; rx_clr = 0; tx_clr = 0; ius_clr = 0;
    endtask

    initial begin
        #(20 * 150000);
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        for (int c = 0; c < 2; c++) begin m_svc[c] = 0; m_prx[c] = 0; m_ptx[c] = 0; end
        m_vec = 8'h06;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset vector", vector, 8'h06);
        chk("R1 reset pending", pending, 8'h00);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
        rst_n = 1;
        @(negedge clk);

        // low-bit encodings and blocking
        rx_set = 2'b10; tick(); chk("R3 A rx", vector, 8'h0C);
        tx_set = 2'b10; tick(); chk("R12 blocked tx", vector, 8'h0C);
        chk("R5 both pending", pending, 8'h30);
        rx_clr = 2'b10; tick(); chk("R7 handoff to tx", vector, 8'h08);
        tx_clr = 2'b10; tick(); chk("R7 to idle", vector, 8'h06);
        tx_set = 2'b01; tick(); chk("R3 B tx", vector, 8'h00);
        ius_clr = 2'b01; tick(); chk("R8 ius clears tx", vector, 8'h06);
        ius_clr = 2'b01; tick(); chk("R8 ius idle", vector, 8'h06);
        chk("R8 ius idle pending", pending, 8'h00);
        rx_set = 2'b01; tick(); chk("R3 B rx", vector, 8'h04);
        rx_clr = 2'b01; tick();
        // high-bit encodings
        status_hi = 1;
        rx_set = 2'b10; tick(); chk("R4 A rx", vector, 8'h30);
        rx_clr = 2'b10; tick(); chk("R4 none", vector, 8'h60);
        tx_set = 2'b10; tick(); chk("R4 A tx", vector, 8'h10);
        tx_clr = 2'b10; tick();
        rx_set = 2'b01; tick(); chk("R4 B rx", vector, 8'h20);
        tx_set = 2'b01; tick();
        rx_clr = 2'b01; tick(); chk("R4 B tx", vector, 8'h00);
        tx_clr = 2'b01; tick(); chk("R4 B none", vector, 8'h60);
        status_hi = 0; tick(); chk("R4 mode change alone", vector, 8'h60);
        // collisions
        rx_set = 2'b10; tx_set = 2'b10; tick();
        chk("R6 rx wins", vector, 8'h0C);
        chk("R6 both pending", pending, 8'h30);
        ius_clr = 2'b10; tx_clr = 2'b10; tick();
        chk("R8 ius over tx_clr", vector, 8'h08);
        chk("R8 tx still pending", pending, 8'h10);
        rx_clr = 2'b10; tx_clr = 2'b10; tick();
        chk("R7 tx_clr ignored", pending, 8'h10);
        tx_clr = 2'b10; tick();
        rx_set = 2'b11; tick(); chk("R9 A wins", vector, 8'h0C);
        // request gating
        int_ctrl_a = 5'b11001; #1; chk("R10 mode 11 off", {6'd0, chan_irq}, 8'h00);
        int_ctrl_a = 5'b01001; #1; chk("R10 mode 01 on", {6'd0, chan_irq}, 8'h02);
        tick(); chk("R11 irq follows", {7'd0, irq}, 8'h01);
        rx_clr = 2'b11; tick();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            rx_set  = {($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0)};
            tx_set  = {($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0)};
            rx_clr  = {($urandom_range(0, 6) == 0), ($urandom_range(0, 6) == 0)};
            tx_clr  = {($urandom_range(0, 6) == 0), ($urandom_range(0, 6) == 0)};
            ius_clr = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)};
            if ($urandom_range(0, 15) == 0) status_hi = $urandom_range(0, 1);
            if ($urandom_range(0, 7) == 0) begin
                int_ctrl_a = 5'($urandom); int_ctrl_b = 5'($urandom);
                brk_en = 2'($urandom); brk_stat = 2'($urandom);
            end
            tick();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule